// File: doc/BRIEF.md
# Event and Duration Profiling Counter

This block is a single profiling counter for performance monitoring inside a larger chip. It observes one monitor line, picked from a small group of inputs, and measures it in one of two ways. In event mode it counts rising transitions of that line. In duration mode it counts ticks of a chosen reference time base while the line is high. Each reference clock is modelled as a synchronous tick-enable input, and clock generation happens outside the block.

The counter advances only while two conditions hold: the shared measurement-window input is high and the counter's own enable bit is set. Software can load or read the count at any time. A clear-all strobe resets it. When the count wraps from all ones to zero, a sticky overflow cause bit is set. That bit has a write-one-to-clear strobe, a software set strobe and a mask. The masked view drives the interrupt output.

Top module: `evprof_counter`

## Requirements
- R1: After reset the count is 0, the cause bit is 0, the mask is 0, and `masked_o` and `irq_o` are 0.
- R2: With `cfg_duration_i`=0 (event mode), each 0-to-1 transition of the selected monitor increments the count once, in the clock edge that samples the new high level. `cfg_ref_sel_i` has no effect in this mode. A monitor that is already high when counting becomes allowed adds nothing.
- R3: With `cfg_duration_i`=1 (duration mode), the count increments at every clock edge where the selected monitor is high and `ref_tick_i[cfg_ref_sel_i]` is high. Select codes 0 to 5 address tick inputs 0 to 5.
- R4: In duration mode, select codes 6 and 7 are reserved and produce no ticks, so the count holds.
- R5: The count changes only by a software write or a clear while `win_active_i` or `cfg_enable_i` is 0.
- R6: Only `mon_i[cfg_mon_sel_i]` is observed. Activity on the other monitor bits does not change the count.
- R7: `cnt_wr_i` loads `cnt_wdata_i` at the next edge and takes priority over a same-cycle increment.
- R8: `clr_all_i` forces the count to 0 and takes priority over both a write and an increment.
- R9: An increment from 0xFFFFFFFF to 0x00000000 sets the cause bit.
- R10: `cause_clr_i`=1 clears the cause bit and `cause_set_i`=1 sets it. A hardware overflow or a software set in the same cycle as a clear leaves the bit set.
- R11: `mask_wr_i` loads the mask from `mask_wdata_i`. `masked_o` equals cause AND mask, and `irq_o` is high exactly when `masked_o` is high.

Two same-cycle cases are not decided by R10: a hardware overflow together with a software set, and all three strobes together. In both the cause bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_active_i | input | 1 | Shared measurement-window active |
| mon_i | input | NUM_MON | Candidate monitor lines |
| ref_tick_i | input | NUM_REF | Reference time-base tick enables |
| cfg_enable_i | input | 1 | Counter enable |
| cfg_duration_i | input | 1 | 0 = count rising edges, 1 = count high duration |
| cfg_ref_sel_i | input | 3 | Reference tick select (6 and 7 reserved) |
| cfg_mon_sel_i | input | clog2(NUM_MON) | Monitor select |
| cnt_wr_i | input | 1 | Software load strobe for the count |
| cnt_wdata_i | input | CNT_W | Value to load |
| clr_all_i | input | 1 | Clear count to zero |
| cause_clr_i | input | 1 | Write-one-to-clear of the overflow cause |
| cause_set_i | input | 1 | Software set of the overflow cause |
| mask_wr_i | input | 1 | Mask load strobe |
| mask_wdata_i | input | 1 | Mask value to load |
| cnt_o | output | CNT_W | Current count |
| cause_o | output | 1 | Sticky overflow cause |
| masked_o | output | 1 | Cause AND mask |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims first at a monitor line that is already high when the window opens. A design that detects edges only while counting is allowed would see a false edge there and count one too many. Reserved reference codes are driven with every tick input high, so a mux that wraps or aliases the select would keep counting. Priority is tested by issuing an increment, a load and a clear in the same cycle. An overflow is also made to coincide with a cause clear: a design that lets the clear win would lose the interrupt. Finally, pulses on monitors that are not selected check that the select mux does not leak.

// File: rtl/evprof_pkg.sv
package evprof_pkg;
   localparam int REF_SEL_W = 3;
   localparam int REF_CODES = 1 << REF_SEL_W;

   typedef enum logic {
      MODE_EVENT    = 1'b0,
      MODE_DURATION = 1'b1
   } cnt_mode_e;

   typedef enum logic [REF_SEL_W-1:0] {
      REF_SRC0  = 3'd0,
      REF_SRC1  = 3'd1,
      REF_SRC2  = 3'd2,
      REF_SRC3  = 3'd3,
      REF_SRC4  = 3'd4,
      REF_SRC5  = 3'd5,
      REF_RSVD6 = 3'd6,
      REF_RSVD7 = 3'd7
   } ref_sel_e;
endpackage

// File: rtl/evprof_trigger.sv
module evprof_trigger #(
   parameter int NUM_MON      = 4,
   parameter int NUM_REF      = 6,
   parameter bit HAS_DURATION = 1'b1,
   parameter int MON_SEL_W    = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_MON-1:0]                mon_i,
   input  logic [NUM_REF-1:0]                ref_tick_i,
   input  logic                              duration_i,
   input  logic [evprof_pkg::REF_SEL_W-1:0]  ref_sel_i,
   input  logic [MON_SEL_W-1:0]              mon_sel_i,
   input  logic                              gate_i,
   output logic                              inc_o
);
   import evprof_pkg::*;

   localparam int MON_SLOTS = 1 << MON_SEL_W;

   logic [NUM_MON-1:0]   mon_prev_q;
   logic [NUM_MON-1:0]   mon_rise;
   logic [MON_SLOTS-1:0] level_pad;
   logic [MON_SLOTS-1:0] rise_pad;
   logic [REF_CODES-1:0] tick_pad;
   logic                 sel_level;
   logic                 sel_rise;
   logic                 sel_tick;

   // Edge history runs every cycle, gated or not, so a line that is
   // already high when counting opens is never mistaken for an edge.
   always_ff @(posedge clk) begin
      if (!rst_n) mon_prev_q <= '0;
      else        mon_prev_q <= mon_i;
   end

   assign mon_rise = mon_i & ~mon_prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < MON_SLOTS; gi++) begin : g_mon_pad
         if (gi < NUM_MON) begin : g_real
            assign level_pad[gi] = mon_i[gi];
            assign rise_pad[gi]  = mon_rise[gi];
         end else begin : g_void
            assign level_pad[gi] = 1'b0;
            assign rise_pad[gi]  = 1'b0;
         end
      end
      for (gi = 0; gi < REF_CODES; gi++) begin : g_tick_pad
         if (gi < NUM_REF) begin : g_real
            assign tick_pad[gi] = ref_tick_i[gi];
         end else begin : g_rsvd
            assign tick_pad[gi] = 1'b0;
         end
      end
   endgenerate

   assign sel_level = level_pad[mon_sel_i];
   assign sel_rise  = rise_pad[mon_sel_i];
   assign sel_tick  = tick_pad[ref_sel_i];

   generate
      if (HAS_DURATION) begin : g_dual_mode
         always_comb begin
            if (cnt_mode_e'(duration_i) == MODE_DURATION)
               inc_o = gate_i & sel_level & sel_tick;
            else
               inc_o = gate_i & sel_rise;
         end
      end else begin : g_event_only
         logic unused_dur;
         assign unused_dur = duration_i ^ sel_level ^ sel_tick;
         assign inc_o = gate_i & sel_rise;
      end
   endgenerate
endmodule

// File: rtl/evprof_count.sv
module evprof_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             bump;

   assign bump  = inc_i & ~wr_i & ~clr_i;
   assign ovf_o = bump & (cnt_q == ALL_ONES);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (wr_i)   cnt_q <= wdata_i;
      else if (bump)   cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/evprof_cause.sv
module evprof_cause (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set_i,
   input  logic sw_set_i,
   input  logic sw_clr_i,
   input  logic mask_wr_i,
   input  logic mask_wdata_i,
   output logic cause_o,
   output logic masked_o
);
   logic cause_q;
   logic mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= 1'b0;
         mask_q  <= 1'b0;
      end else begin
         cause_q <= hw_set_i | sw_set_i | (cause_q & ~sw_clr_i);
         if (mask_wr_i) mask_q <= mask_wdata_i;
      end
   end

   assign cause_o  = cause_q;
   assign masked_o = cause_q & mask_q;
endmodule

// File: rtl/evprof_counter.sv
module evprof_counter #(
   parameter int CNT_W        = 32,
   parameter int NUM_MON      = 4,
   parameter int NUM_REF      = 6,
   parameter bit HAS_DURATION = 1'b1
) (
   input  logic                                            clk,
   input  logic                                            rst_n,
   input  logic                                            win_active_i,
   input  logic [NUM_MON-1:0]                              mon_i,
   input  logic [NUM_REF-1:0]                              ref_tick_i,
   input  logic                                            cfg_enable_i,
   input  logic                                            cfg_duration_i,
   input  logic [2:0]                                      cfg_ref_sel_i,
   input  logic [$clog2((NUM_MON > 1) ? NUM_MON : 2)-1:0]  cfg_mon_sel_i,
   input  logic                                            cnt_wr_i,
   input  logic [CNT_W-1:0]                                cnt_wdata_i,
   input  logic                                            clr_all_i,
   input  logic                                            cause_clr_i,
   input  logic                                            cause_set_i,
   input  logic                                            mask_wr_i,
   input  logic                                            mask_wdata_i,
   output logic [CNT_W-1:0]                                cnt_o,
   output logic                                            cause_o,
   output logic                                            masked_o,
   output logic                                            irq_o
);
   import evprof_pkg::*;

   localparam int MON_SEL_W = $clog2((NUM_MON > 1) ? NUM_MON : 2);

   generate
      if (CNT_W < 2 || CNT_W > 64) begin : g_bad_cnt_w
         $error("evprof_counter: CNT_W must be within 2..64");
      end
      if (NUM_MON < 1) begin : g_bad_mon
         $error("evprof_counter: NUM_MON must be at least 1");
      end
      if (NUM_REF < 1 || NUM_REF > REF_CODES) begin : g_bad_ref
         $error("evprof_counter: NUM_REF must be within 1..8");
      end
   endgenerate

   logic gate;
   logic inc;
   logic ovf;

   assign gate = win_active_i & cfg_enable_i;

   evprof_trigger #(
      .NUM_MON      (NUM_MON),
      .NUM_REF      (NUM_REF),
      .HAS_DURATION (HAS_DURATION),
      .MON_SEL_W    (MON_SEL_W)
   ) u_trigger (
      .clk        (clk),
      .rst_n      (rst_n),
      .mon_i      (mon_i),
      .ref_tick_i (ref_tick_i),
      .duration_i (cfg_duration_i),
      .ref_sel_i  (cfg_ref_sel_i),
      .mon_sel_i  (cfg_mon_sel_i),
      .gate_i     (gate),
      .inc_o      (inc)
   );

   evprof_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (inc),
      .wr_i    (cnt_wr_i),
      .wdata_i (cnt_wdata_i),
      .clr_i   (clr_all_i),
      .cnt_o   (cnt_o),
      .ovf_o   (ovf)
   );

   evprof_cause u_cause (
      .clk          (clk),
      .rst_n        (rst_n),
      .hw_set_i     (ovf),
      .sw_set_i     (cause_set_i),
      .sw_clr_i     (cause_clr_i),
      .mask_wr_i    (mask_wr_i),
      .mask_wdata_i (mask_wdata_i),
      .cause_o      (cause_o),
      .masked_o     (masked_o)
   );

   assign irq_o = masked_o;
endmodule

// File: rtl/evprof_counter_chk.sv
module evprof_counter_chk #(
   parameter int CNT_W   = 32,
   parameter int NUM_REF = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             win_active_i,
   input logic             cfg_enable_i,
   input logic             cfg_duration_i,
   input logic [2:0]       cfg_ref_sel_i,
   input logic             cnt_wr_i,
   input logic [CNT_W-1:0] cnt_wdata_i,
   input logic             clr_all_i,
   input logic             cause_set_i,
   input logic             mask_wr_i,
   input logic             mask_wdata_i,
   input logic [CNT_W-1:0] cnt_o,
   input logic             cause_o,
   input logic             masked_o,
   input logic             irq_o
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   p_closed_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((!win_active_i || !cfg_enable_i) && !cnt_wr_i && !clr_all_i) |=> $stable(cnt_o));

   p_reserved_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_duration_i && (int'(cfg_ref_sel_i) >= NUM_REF) && !cnt_wr_i && !clr_all_i)
      |=> $stable(cnt_o));

   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr_i && !clr_all_i) |=> (cnt_o == $past(cnt_wdata_i)));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_i |=> (cnt_o == '0));

   p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr_i && !clr_all_i) |=>
      ((cnt_o == $past(cnt_o)) || (cnt_o == CNT_W'($past(cnt_o) + 1'b1))));

   p_wrap_sets_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr_i && !clr_all_i && (cnt_o == ALL_ONES)) |=>
      ((cnt_o == '0) ? cause_o : 1'b1));

   p_sw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cause_set_i |=> cause_o);

   p_masked_needs_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      masked_o |-> cause_o);

   p_mask_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr_i && !mask_wdata_i) |=> !masked_o);

   p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == masked_o);
endmodule

bind evprof_counter evprof_counter_chk #(
   .CNT_W   (CNT_W),
   .NUM_REF (NUM_REF)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .win_active_i   (win_active_i),
   .cfg_enable_i   (cfg_enable_i),
   .cfg_duration_i (cfg_duration_i),
   .cfg_ref_sel_i  (cfg_ref_sel_i),
   .cnt_wr_i       (cnt_wr_i),
   .cnt_wdata_i    (cnt_wdata_i),
   .clr_all_i      (clr_all_i),
   .cause_set_i    (cause_set_i),
   .mask_wr_i      (mask_wr_i),
   .mask_wdata_i   (mask_wdata_i),
   .cnt_o          (cnt_o),
   .cause_o        (cause_o),
   .masked_o       (masked_o),
   .irq_o          (irq_o)
);

// File: tb/evprof_counter_bench.sv
`timescale 1ns/1ps
module evprof_counter_bench;
   localparam int CNT_W   = 32;
   localparam int NUM_MON = 4;
   localparam int NUM_REF = 6;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               win_active_i;
   logic [NUM_MON-1:0] mon_i;
   logic [NUM_REF-1:0] ref_tick_i;
   logic               cfg_enable_i;
   logic               cfg_duration_i;
   logic [2:0]         cfg_ref_sel_i;
   logic [1:0]         cfg_mon_sel_i;
   logic               cnt_wr_i;
   logic [CNT_W-1:0]   cnt_wdata_i;
   logic               clr_all_i;
   logic               cause_clr_i;
   logic               cause_set_i;
   logic               mask_wr_i;
   logic               mask_wdata_i;
   logic [CNT_W-1:0]   cnt_o;
   logic               cause_o;
   logic               masked_o;
   logic               irq_o;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   evprof_counter #(
      .CNT_W   (CNT_W),
      .NUM_MON (NUM_MON),
      .NUM_REF (NUM_REF)
   ) u_evprof_counter (
      .clk            (clk),
      .rst_n          (rst_n),
      .win_active_i   (win_active_i),
      .mon_i          (mon_i),
      .ref_tick_i     (ref_tick_i),
      .cfg_enable_i   (cfg_enable_i),
      .cfg_duration_i (cfg_duration_i),
      .cfg_ref_sel_i  (cfg_ref_sel_i),
      .cfg_mon_sel_i  (cfg_mon_sel_i),
      .cnt_wr_i       (cnt_wr_i),
      .cnt_wdata_i    (cnt_wdata_i),
      .clr_all_i      (clr_all_i),
      .cause_clr_i    (cause_clr_i),
      .cause_set_i    (cause_set_i),
      .mask_wr_i      (mask_wr_i),
      .mask_wdata_i   (mask_wdata_i),
      .cnt_o          (cnt_o),
      .cause_o        (cause_o),
      .masked_o       (masked_o),
      .irq_o          (irq_o)
   );

   // One edge, then settle 1 ns past it before driving or sampling.
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic load_count(input logic [CNT_W-1:0] v);
      cnt_wr_i = 1'b1; cnt_wdata_i = v;
      tick();
      cnt_wr_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 count", cnt_o, 0);
      check("R1 cause", cause_o, 0);
      check("R1 masked", masked_o, 0);
      check("R1 irq", irq_o, 0);
      // A zero mask must be in place: setting the cause leaves masked low
      cause_set_i = 1'b1; tick(); cause_set_i = 1'b0;
      check("R1 mask reset value", masked_o, 0);
      cause_clr_i = 1'b1; tick(); cause_clr_i = 1'b0;
   endtask

   task automatic t_event();
      cfg_enable_i = 1'b1; cfg_duration_i = 1'b0; cfg_mon_sel_i = 2'd1;
      cfg_ref_sel_i = 3'd7; ref_tick_i = '0; win_active_i = 1'b1;
      load_count(0);
      mon_i[1] = 1'b1; tick(); tick(); tick();
      check("R2 first rising edge counted once", cnt_o, 1);
      mon_i[1] = 1'b0; tick();
      mon_i[1] = 1'b1; tick();
      mon_i[1] = 1'b0; tick();
      check("R2 two edges with reserved ref select ignored", cnt_o, 2);
      for (int i = 0; i < 6; i++) begin
         mon_i[0] = ~mon_i[0]; mon_i[3] = ~mon_i[3]; tick();
      end
      check("R6 unselected monitors ignored", cnt_o, 2);
      // line rises while the window is closed, then the window opens
      win_active_i = 1'b0; mon_i[1] = 1'b1; tick(); tick();
      win_active_i = 1'b1; tick(); tick(); tick();
      check("R2 already-high monitor at window open", cnt_o, 2);
      mon_i = '0; tick();
   endtask

   task automatic t_duration();
      int exp_cnt;
      cfg_duration_i = 1'b1; cfg_ref_sel_i = 3'd2; cfg_mon_sel_i = 2'd0;
      load_count(0);
      exp_cnt = 0;
      for (int i = 0; i < 10; i++) begin
         mon_i[0]   = (i != 6);
         ref_tick_i = 6'b000001;
         ref_tick_i[2] = (i % 3 == 0);
         if (mon_i[0] && ref_tick_i[2]) exp_cnt++;
         tick();
      end
      check("R3 duration ticks from source 2", cnt_o, exp_cnt);
      ref_tick_i = '0;
      cfg_ref_sel_i = 3'd5; mon_i[0] = 1'b1; ref_tick_i[5] = 1'b1;
      tick(); tick();
      check("R3 duration ticks from source 5", cnt_o, exp_cnt + 2);
   endtask

   task automatic t_reserved();
      logic [CNT_W-1:0] base;
      base = cnt_o;
      mon_i = '1; ref_tick_i = '1;
      cfg_ref_sel_i = 3'd6; tick(); tick(); tick();
      cfg_ref_sel_i = 3'd7; tick(); tick(); tick();
      check("R4 reserved codes hold count", cnt_o, base);
   endtask

   task automatic t_gate();
      logic [CNT_W-1:0] base;
      cfg_ref_sel_i = 3'd0; mon_i = '1; ref_tick_i = '1;
      base = cnt_o;
      win_active_i = 1'b0; cfg_enable_i = 1'b1; tick(); tick(); tick();
      check("R5 window closed holds", cnt_o, base);
      win_active_i = 1'b1; cfg_enable_i = 1'b0; tick(); tick(); tick();
      check("R5 counter disabled holds", cnt_o, base);
      cfg_enable_i = 1'b1; tick();
      check("R5 both set resumes counting", cnt_o, base + 1);
   endtask

   task automatic t_write_clear();
      // counting is active every cycle here (duration, ref 0, all high)
      cnt_wr_i = 1'b1; cnt_wdata_i = 32'h1234_5678; tick(); cnt_wr_i = 1'b0;
      check("R7 write beats increment", cnt_o, 32'h1234_5678);
      tick();
      check("R7 counting continues from written value", cnt_o, 32'h1234_5679);
      clr_all_i = 1'b1; cnt_wr_i = 1'b1; cnt_wdata_i = 32'hDEAD_BEEF;
      tick();
      clr_all_i = 1'b0; cnt_wr_i = 1'b0; win_active_i = 1'b0;
      check("R8 clear beats write and increment", cnt_o, 0);
      win_active_i = 1'b1;
   endtask

   task automatic t_overflow();
      win_active_i = 1'b0;
      load_count(32'hFFFF_FFFE);
      win_active_i = 1'b1; tick();
      check("R9 no cause before wrap", cause_o, 0);
      check("R9 count at all ones", cnt_o, 32'hFFFF_FFFF);
      tick();
      check("R9 wrap to zero", cnt_o, 0);
      check("R9 wrap sets cause", cause_o, 1);
      win_active_i = 1'b0;
      cause_clr_i = 1'b1; tick(); cause_clr_i = 1'b0;
      check("R10 write-one clears cause", cause_o, 0);
      load_count(32'hFFFF_FFFF);
      win_active_i = 1'b1; cause_clr_i = 1'b1; tick();
      cause_clr_i = 1'b0; win_active_i = 1'b0;
      check("R10 overflow beats same-cycle clear", cause_o, 1);
      cause_clr_i = 1'b1; tick(); cause_clr_i = 1'b0;
      cause_set_i = 1'b1; tick(); cause_set_i = 1'b0;
      check("R10 software set", cause_o, 1);
   endtask

   task automatic t_mask();
      check("R11 masked low with mask 0", masked_o, 0);
      check("R11 irq low with mask 0", irq_o, 0);
      mask_wr_i = 1'b1; mask_wdata_i = 1'b1; tick(); mask_wr_i = 1'b0;
      check("R11 masked follows cause", masked_o, 1);
      check("R11 irq raised", irq_o, 1);
      cause_clr_i = 1'b1; tick(); cause_clr_i = 1'b0;
      check("R11 masked drops with cause", masked_o, 0);
      check("R11 irq drops with cause", irq_o, 0);
   endtask

   initial begin
      rst_n = 1'b0; win_active_i = 1'b0; mon_i = '0; ref_tick_i = '0;
      cfg_enable_i = 1'b0; cfg_duration_i = 1'b0; cfg_ref_sel_i = '0;
      cfg_mon_sel_i = '0; cnt_wr_i = 1'b0; cnt_wdata_i = '0; clr_all_i = 1'b0;
      cause_clr_i = 1'b0; cause_set_i = 1'b0; mask_wr_i = 1'b0; mask_wdata_i = 1'b0;
      tick(); tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_event();
      t_duration();
      t_reserved();
      t_gate();
      t_write_clear();
      t_overflow();
      t_mask();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule